// File: doc/BRIEF.md
# Smart Card Activation and Fault Controller

This block sits between a host control bus and the analog front end of a contact smart card slot. It sequences card power-up and power-down. The host lowers an active-low power command to start a session, asks for card reset through a request line, and picks a 3 V or 5 V card supply. The block then drives the supply enable, the I/O release, the clock enable and the card reset in a fixed order. Each step is separated by a count of system clock cycles.

Two presence switches of opposite polarity tell the block whether a card is inserted. Five digital flags report the front end's protection results: card over-current, card supply low, regulator supply low, digital supply low and over-temperature. If the card is pulled out, or any flag rises while the card is powered, the block runs the power-down order on its own. It also pulls its single active-low interrupt low so the host can tell what happened. All presence and flag inputs are resynchronised inside the block, and presence is also debounced.

Top module: `sc_card_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `card_pwr_en`, `card_5v`, `card_io_en`, `card_clk_en` and `card_rst` are 0 and `irq_n` is 1.
- R2: A card counts as present when `pres_hi` is 1 or `pres_lo_n` is 0. After a two-flop synchroniser, a new presence value is accepted only once it has held for `DEB_CYCLES` consecutive cycles, so shorter glitches are dropped. Every accepted change pulls `irq_n` low one cycle later.
- R3: A 1-to-0 edge on `pwr_cmd_n` while idle, with a card present and no flag set, starts activation. `card_pwr_en` rises first. `card_io_en` rises `step_cycles`+1 cycles later, and `card_clk_en` rises a further `step_cycles`+1 cycles after that.
- R4: `card_5v` takes the value of `vsel_5v` (1 = 5 V) in the cycle activation starts. It holds that value for the whole session and returns to 0 when the supply is switched off.
- R5: `card_rst` stays 0 until activation has finished, which is `step_cycles`+1 cycles after the clock is enabled. From then on it copies `rst_req` with one cycle of delay.
- R6: `pwr_cmd_n` at 1 during activation or a session starts deactivation. `card_rst` drops at once. `card_clk_en`, then `card_io_en`, then `card_pwr_en` (with `card_5v`) drop in turn, each `DEACT_GAP`+1 cycles after the previous step.
- R7: Card removal, or any of the five fault flags (after synchronisation), during activation or a session starts the same deactivation as R6. A flag seen while the card is powered, including during deactivation, pulls `irq_n` low.
- R8: A falling edge of `pwr_cmd_n` is ignored, and leaves `card_pwr_en` at 0, in any of these cases: deactivation is still running, a fault flag is set, or no card is present.
- R9: `irq_n`, once low, returns to 1 only on a rising edge of `pwr_cmd_n` with no fault flag set. A new event in the same cycle keeps it low.
- R10: A fault flag raised while the card is unpowered leaves `irq_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_cmd_n | input | 1 | Host power command, active low |
| rst_req | input | 1 | Host card reset request |
| vsel_5v | input | 1 | Supply select, 1 = 5 V, 0 = 3 V |
| step_cycles | input | STEP_W | Activation step spacing minus one |
| pres_hi | input | 1 | Presence switch, active high |
| pres_lo_n | input | 1 | Presence switch, active low |
| flt_ocur | input | 1 | Card over-current flag |
| flt_vcard | input | 1 | Card supply low flag |
| flt_vreg | input | 1 | Regulator supply low flag |
| flt_vdig | input | 1 | Digital supply low flag |
| flt_temp | input | 1 | Over-temperature flag |
| card_pwr_en | output | 1 | Card supply enable |
| card_5v | output | 1 | Card supply level, 1 = 5 V |
| card_io_en | output | 1 | I/O released to reception (0 = held low) |
| card_clk_en | output | 1 | Card clock running (0 = stopped low) |
| card_rst | output | 1 | Card reset line |
| irq_n | output | 1 | Host interrupt, active low |

## Verification
Presence is driven through each switch in turn. It is also handed from one switch to the other, which must not count as a change, and given a glitch shorter than the debounce window, which must be dropped. Sessions are opened with different step counts and both supply levels. They are then closed by the host, by card removal and by each of the five flags in turn, so the bench can check that every route follows the same ordered shutdown. Falling edges arrive while a fault is held, while the card is absent and while shutdown is still running, which separates a refused start from a real one. Flags held across the host's release, and flags pulsed while idle, show when the interrupt may clear and when it must not move.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int NFLT = 5;
  localparam int NSYNC = NFLT + 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACT   = 2'd1,
    ST_ON    = 2'd2,
    ST_DEACT = 2'd3
  } sc_state_e;
endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic s1, s2;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1 <= 1'b0;
          s2 <= 1'b0;
        end else begin
          s1 <= d[i];
          s2 <= s1;
        end
      end
      assign q[i] = s2;
    end
  endgenerate
endmodule

// File: rtl/sc_debounce.sv
module sc_debounce #(
  parameter int DEB_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic pres,
  output logic chg
);
  localparam int CW = (DEB_CYCLES > 2) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pres <= 1'b0;
      chg  <= 1'b0;
      cnt  <= '0;
    end else if (raw == pres) begin
      cnt <= '0;
      chg <= 1'b0;
    end else if (cnt == LAST) begin
      pres <= raw;
      chg  <= 1'b1;
      cnt  <= '0;
    end else begin
      cnt <= cnt + CW'(1);
      chg <= 1'b0;
    end
  end

  // R2: an accepted value is the raw level seen on the previous cycle
  a_r2_accept_raw: assert property (@(posedge clk) disable iff (rst)
    chg |-> (pres == $past(raw)));
  // R2: presence moves only together with a change pulse
  a_r2_move_flagged: assert property (@(posedge clk) disable iff (rst)
    !chg |-> $stable(pres));
endmodule

// File: rtl/sc_seq.sv
module sc_seq
  import sc_pkg::*;
#(
  parameter int STEP_W    = 8,
  parameter int DEACT_GAP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_n,
  input  logic              rst_req,
  input  logic              vsel_5v,
  input  logic [STEP_W-1:0] step_cycles,
  input  logic              pres,
  input  logic              pres_chg,
  input  logic              fault,
  output logic              pwr_en,
  output logic              v5,
  output logic              io_en,
  output logic              clk_en,
  output logic              card_rst,
  output logic              irq_n
);
  localparam int GW = (DEACT_GAP > 1) ? $clog2(DEACT_GAP + 1) : 1;
  localparam int TW = (STEP_W > GW) ? STEP_W : GW;
  localparam logic [TW-1:0] GAP = TW'(DEACT_GAP);

  sc_state_e     st;
  logic [1:0]    stp;
  logic [TW-1:0] tmr;
  logic          cmd_q;

  logic cmd_fall, cmd_rise, abort, irq_set, irq_clr;
  assign cmd_fall = cmd_q & ~cmd_n;
  assign cmd_rise = ~cmd_q & cmd_n;
  assign abort    = cmd_n | fault | ~pres;
  assign irq_set  = pres_chg | (fault & (st != ST_IDLE));
  assign irq_clr  = cmd_rise & ~fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      stp      <= 2'd0;
      tmr      <= '0;
      cmd_q    <= 1'b1;
      pwr_en   <= 1'b0;
      v5       <= 1'b0;
      io_en    <= 1'b0;
      clk_en   <= 1'b0;
      card_rst <= 1'b0;
      irq_n    <= 1'b1;
    end else begin
      cmd_q <= cmd_n;
      irq_n <= ~(irq_set | (~irq_n & ~irq_clr));
      case (st)
        ST_IDLE: begin
          if (cmd_fall && pres && !fault) begin
            st     <= ST_ACT;
            pwr_en <= 1'b1;
            v5     <= vsel_5v;
            stp    <= 2'd0;
            tmr    <= TW'(step_cycles);
          end
        end
        ST_ACT, ST_ON: begin
          if (abort) begin
            st       <= ST_DEACT;
            card_rst <= 1'b0;
            stp      <= 2'd0;
            tmr      <= GAP;
          end else if (st == ST_ON) begin
            card_rst <= rst_req;
          end else if (tmr != '0) begin
            tmr <= tmr - TW'(1);
          end else begin
            case (stp)
              2'd0: begin io_en  <= 1'b1; stp <= 2'd1; tmr <= TW'(step_cycles); end
              2'd1: begin clk_en <= 1'b1; stp <= 2'd2; tmr <= TW'(step_cycles); end
              default: st <= ST_ON;
            endcase
          end
        end
        ST_DEACT: begin
          if (tmr != '0) begin
            tmr <= tmr - TW'(1);
          end else begin
            case (stp)
              2'd0: begin clk_en <= 1'b0; stp <= 2'd1; tmr <= GAP; end
              2'd1: begin io_en  <= 1'b0; stp <= 2'd2; tmr <= GAP; end
              default: begin
                pwr_en <= 1'b0;
                v5     <= 1'b0;
                st     <= ST_IDLE;
              end
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r3_io_under_pwr: assert property (@(posedge clk) disable iff (rst)
    io_en |-> pwr_en);
  a_r3_clk_under_io: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> io_en);
  a_r5_rst_in_session: assert property (@(posedge clk) disable iff (rst)
    card_rst |-> (clk_en && st == ST_ON));
  a_r4_level_held: assert property (@(posedge clk) disable iff (rst)
    (pwr_en && $past(pwr_en)) |-> $stable(v5));
  a_r7_fault_shutdown: assert property (@(posedge clk) disable iff (rst)
    (fault && (st == ST_ACT || st == ST_ON)) |=> (st == ST_DEACT && !card_rst));
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DEACT) |=> (st == ST_DEACT || (st == ST_IDLE && !pwr_en)));
  a_r9_irq_kept: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && fault) |=> !irq_n);
endmodule

// File: rtl/sc_card_ctrl.sv
module sc_card_ctrl
  import sc_pkg::*;
#(
  parameter int STEP_W     = 8,
  parameter int DEACT_GAP  = 4,
  parameter int DEB_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_cmd_n,
  input  logic              rst_req,
  input  logic              vsel_5v,
  input  logic [STEP_W-1:0] step_cycles,
  input  logic              pres_hi,
  input  logic              pres_lo_n,
  input  logic              flt_ocur,
  input  logic              flt_vcard,
  input  logic              flt_vreg,
  input  logic              flt_vdig,
  input  logic              flt_temp,
  output logic              card_pwr_en,
  output logic              card_5v,
  output logic              card_io_en,
  output logic              card_clk_en,
  output logic              card_rst,
  output logic              irq_n
);
  logic [NSYNC-1:0] async_in, synced;
  logic pres_raw, pres, pres_chg, fault;

  // bit 0/1: presence switches normalised to active high; upper bits: flags
  assign async_in = {flt_temp, flt_vdig, flt_vreg, flt_vcard, flt_ocur,
                     ~pres_lo_n, pres_hi};

  sc_sync #(.W(NSYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (async_in),
    .q   (synced)
  );

  assign pres_raw = synced[0] | synced[1];
  assign fault    = |synced[NSYNC-1:2];

  sc_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk  (clk),
    .rst  (rst),
    .raw  (pres_raw),
    .pres (pres),
    .chg  (pres_chg)
  );

  sc_seq #(.STEP_W(STEP_W), .DEACT_GAP(DEACT_GAP)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cmd_n       (pwr_cmd_n),
    .rst_req     (rst_req),
    .vsel_5v     (vsel_5v),
    .step_cycles (step_cycles),
    .pres        (pres),
    .pres_chg    (pres_chg),
    .fault       (fault),
    .pwr_en      (card_pwr_en),
    .v5          (card_5v),
    .io_en       (card_io_en),
    .clk_en      (card_clk_en),
    .card_rst    (card_rst),
    .irq_n       (irq_n)
  );
endmodule

// File: tb/sc_card_ctrl_tb.sv
module sc_card_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STEP_W = 8;
  localparam int DGAP = 4;
  localparam int DEB = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_cmd_n = 1'b1, rst_req = 1'b0, vsel_5v = 1'b0;
  logic [STEP_W-1:0] step_cycles = 8'd3;
  logic pres_hi = 1'b0, pres_lo_n = 1'b1;
  logic [4:0] flt = 5'b0;
  logic card_pwr_en, card_5v, card_io_en, card_clk_en, card_rst, irq_n;

  int nchk = 0, nfail = 0;
  bit done = 0, seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_card_ctrl #(.STEP_W(STEP_W), .DEACT_GAP(DGAP), .DEB_CYCLES(DEB)) u_dut (
    .clk(clk), .rst(rst), .pwr_cmd_n(pwr_cmd_n), .rst_req(rst_req),
    .vsel_5v(vsel_5v), .step_cycles(step_cycles),
    .pres_hi(pres_hi), .pres_lo_n(pres_lo_n),
    .flt_ocur(flt[0]), .flt_vcard(flt[1]), .flt_vreg(flt[2]),
    .flt_vdig(flt[3]), .flt_temp(flt[4]),
    .card_pwr_en(card_pwr_en), .card_5v(card_5v), .card_io_en(card_io_en),
    .card_clk_en(card_clk_en), .card_rst(card_rst), .irq_n(irq_n)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit q1[7], q2[7];
  int dcnt;
  bit m_pres, m_chg, m_cmdq;
  int phase;   // 0 idle, 1 powering up, 2 session, 3 powering down
  int step, wait_left;
  bit m_pwr, m_v5, m_io, m_clk, m_rst, m_irqn;

  always @(posedge clk) begin
    bit flt_any, raw, rise, fall, stop;
    seen = 1;
    if (rst) begin
      foreach (q1[i]) begin q1[i] = 0; q2[i] = 0; end
      dcnt = 0; m_pres = 0; m_chg = 0; m_cmdq = 1;
      phase = 0; step = 0; wait_left = 0;
      m_pwr = 0; m_v5 = 0; m_io = 0; m_clk = 0; m_rst = 0; m_irqn = 1;
    end else begin
      flt_any = q2[2] | q2[3] | q2[4] | q2[5] | q2[6];
      rise = !m_cmdq && pwr_cmd_n;
      fall = m_cmdq && !pwr_cmd_n;
      stop = pwr_cmd_n || flt_any || !m_pres;
      if (m_chg || (flt_any && phase != 0)) m_irqn = 0;
      else if (rise && !flt_any) m_irqn = 1;
      m_cmdq = pwr_cmd_n;
      if (phase == 0) begin
        if (fall && m_pres && !flt_any) begin
          phase = 1; m_pwr = 1; m_v5 = vsel_5v; step = 0; wait_left = step_cycles;
        end
      end else if (phase == 1 || phase == 2) begin
        if (stop) begin
          phase = 3; m_rst = 0; step = 0; wait_left = DGAP;
        end else if (phase == 2) m_rst = rst_req;
        else if (wait_left > 0) wait_left--;
        else if (step == 0) begin m_io = 1; step = 1; wait_left = step_cycles; end
        else if (step == 1) begin m_clk = 1; step = 2; wait_left = step_cycles; end
        else phase = 2;
      end else begin
        if (wait_left > 0) wait_left--;
        else if (step == 0) begin m_clk = 0; step = 1; wait_left = DGAP; end
        else if (step == 1) begin m_io = 0; step = 2; wait_left = DGAP; end
        else begin m_pwr = 0; m_v5 = 0; phase = 0; end
      end
      raw = q2[0] | q2[1];
      if (raw == m_pres) begin dcnt = 0; m_chg = 0; end
      else if (dcnt == DEB - 1) begin m_pres = raw; dcnt = 0; m_chg = 1; end
      else begin dcnt++; m_chg = 0; end
      foreach (q2[i]) q2[i] = q1[i];
      q1[0] = pres_hi; q1[1] = !pres_lo_n;
      for (int k = 0; k < 5; k++) q1[k+2] = flt[k];
    end
  end

  always @(negedge clk) begin
    if (seen && !done) begin
      chk(card_pwr_en, m_pwr, "R3/R6 model card_pwr_en");
      chk(card_5v,     m_v5,  "R4 model card_5v");
      chk(card_io_en,  m_io,  "R3/R6 model card_io_en");
      chk(card_clk_en, m_clk, "R3/R6 model card_clk_en");
      chk(card_rst,    m_rst, "R5 model card_rst");
      chk(irq_n,       m_irqn,"R2/R7/R9 model irq_n");
    end
  end

  // ---------------- stimulus ----------------
  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wt(4);
    chk(card_pwr_en, 1'b0, "R1 reset pwr");
    chk(card_io_en,  1'b0, "R1 reset io");
    chk(card_clk_en, 1'b0, "R1 reset clk");
    chk(card_rst,    1'b0, "R1 reset rst");
    chk(irq_n,       1'b1, "R1 reset irq_n");
    rst = 0;
    wt(1);
    chk(card_5v, 1'b0, "R1 after reset 5v");
    // R2 glitch shorter than the debounce window
    pres_hi = 1; wt(4); pres_hi = 0; wt(20);
    chk(irq_n, 1'b1, "R2 glitch dropped");
    // R2 insertion
    pres_hi = 1; wt(20);
    chk(irq_n, 1'b0, "R2 insertion irq");
    // R8 start refused while a flag is set; R10 flag idle
    flt[2] = 1; wt(4);
    pwr_cmd_n = 0; wt(20);
    chk(card_pwr_en, 1'b0, "R8 refused under fault");
    pwr_cmd_n = 1; wt(2); flt[2] = 0; wt(4);
    // R3/R4/R5 activation at 5 V
    vsel_5v = 1; pwr_cmd_n = 0; wt(30);
    chk(card_pwr_en, 1'b1, "R3 pwr on");
    chk(card_io_en,  1'b1, "R3 io on");
    chk(card_clk_en, 1'b1, "R3 clk on");
    chk(card_5v,     1'b1, "R4 5v captured");
    chk(card_rst,    1'b0, "R5 rst held low");
    vsel_5v = 0; wt(2);
    chk(card_5v, 1'b1, "R4 level held");
    rst_req = 1; wt(3);
    chk(card_rst, 1'b1, "R5 rst follows");
    // R6 host release; R8 fall during shutdown ignored; R9 cleared
    pwr_cmd_n = 1; wt(2);
    chk(card_rst, 1'b0, "R6 rst drops first");
    pwr_cmd_n = 0; wt(40);
    chk(card_pwr_en, 1'b0, "R8 no restart during shutdown");
    chk(irq_n, 1'b1, "R9 cleared by release");
    pwr_cmd_n = 1; rst_req = 0; wt(3);
    // R2 handover between switches is not a change
    pres_lo_n = 0; wt(4); pres_hi = 0; wt(20);
    chk(irq_n, 1'b1, "R2 handover no change");
    // R7 over-current at 3 V, step 1
    step_cycles = 8'd1; pwr_cmd_n = 0; wt(25);
    chk(card_pwr_en, 1'b1, "R3 pwr on short step");
    chk(card_5v, 1'b0, "R4 3v captured");
    flt[0] = 1; wt(40);
    chk(card_pwr_en, 1'b0, "R7 fault shutdown");
    chk(irq_n, 1'b0, "R7 fault irq");
    pwr_cmd_n = 1; wt(3);
    chk(irq_n, 1'b0, "R9 kept while fault held");
    flt[0] = 0; wt(4);
    pwr_cmd_n = 0; wt(20); pwr_cmd_n = 1; wt(40);
    chk(irq_n, 1'b1, "R9 cleared after fault gone");
    // R10 flag while unpowered
    flt[4] = 1; wt(3); flt[4] = 0; wt(10);
    chk(irq_n, 1'b1, "R10 idle fault ignored");
    // R7 removal during a session
    pwr_cmd_n = 0; wt(25);
    pres_lo_n = 1; wt(50);
    chk(card_pwr_en, 1'b0, "R7 removal shutdown");
    chk(irq_n, 1'b0, "R7 removal irq");
    pwr_cmd_n = 1; wt(3);
    pwr_cmd_n = 0; wt(20);
    chk(card_pwr_en, 1'b0, "R8 refused without card");
    pwr_cmd_n = 1; pres_hi = 1; wt(20);
    // R7 every flag in turn
    step_cycles = 8'd2;
    for (int k = 0; k < 5; k++) begin
      pwr_cmd_n = 0; wt(30);
      chk(card_clk_en, 1'b1, "R3 session up before flag");
      flt[k] = 1; wt(40);
      chk(card_pwr_en, 1'b0, "R7 flag shutdown");
      flt[k] = 0; pwr_cmd_n = 1; wt(6);
    end
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule